// File: doc/BRIEF.md
# Byte-Lane Parity Generator and Checker

This block sits beside a 32-bit data bus that carries one parity bit for each byte. On the write side it produces an even-parity bit for every byte lane. The bit appears in the same cycle as the write word, so it stays aligned with the data for as many clocks as the data is held. On the read side it watches the two ready strobes. When either strobe is low on a clock edge during a read, it takes a snapshot of the read word, the incoming parity bits and the set of lanes that matter for that transfer. During the following clock only, it drives an active-low parity status output.

Which lanes count depends on two things: the active-low byte enables and the two active-low bus-width indications. On a narrow bus, only the lanes that actually carry the transfer are judged. The status is for reporting only. The captured read word is handed on unchanged together with a one-clock valid pulse. That result path has no ready input and no back-pressure: the pulse must be consumed in the clock it appears. All other pins are plain level-sampled control signals.

Top module: `lane_parity_unit`

## Requirements
- R1: `wr_par[i]` is the XOR of `wr_data[8i+7:8i]`, so each lane byte plus its parity bit holds an even number of ones. It is combinational from `wr_data`, so it is valid in the same cycle as the data.
- R2: A read transfer is accepted on any rising clock edge where `is_write` is 0 and at least one of `rdy_n` or `brdy_n` is 0. Both strobes low together count as one transfer.
- R3: In the clock after an accepted read, `chk_n` is 0 if and only if at least one participating lane holds an odd number of ones over its byte and its `rd_par` bit.
- R4: On a full-width bus (`bus16_n`=1, `bus8_n`=1), lane i participates exactly when `be_n[i]` is 0.
- R5: On a 16-bit bus (`bus16_n`=0, `bus8_n`=1), the enabled lanes of the lower half (lanes 0 and 1) participate if either of them is enabled. Otherwise the enabled lanes of the upper half (lanes 2 and 3) participate.
- R6: On an 8-bit bus (`bus8_n`=0, which overrides `bus16_n`), only the lowest-numbered enabled lane participates.
- R7: In every clock that does not directly follow an accepted read, `chk_n` is 1.
- R8: A ready strobe while `is_write` is 1 produces neither a status pulse nor `rd_vld`.
- R9: In the clock after an accepted read, `rd_vld` is 1 and `rd_word` equals the word sampled, whatever the parity result. At all other times `rd_vld` is 0.
- R10: A synchronous active-high `rst` sets `chk_n` to 1, `rd_vld` to 0 and `rd_word` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| is_write | input | 1 | 1 = write cycle, 0 = read cycle |
| be_n | input | 4 | Byte enables, active low, bit i for lane i |
| bus16_n | input | 1 | 16-bit bus width indication, active low |
| bus8_n | input | 1 | 8-bit bus width indication, active low |
| rdy_n | input | 1 | Single-transfer ready strobe, active low |
| brdy_n | input | 1 | Burst ready strobe, active low |
| wr_data | input | 32 | Write word |
| wr_par | output | 4 | Even parity of each write byte |
| rd_data | input | 32 | Read word from the bus |
| rd_par | input | 4 | Parity bits returned with the read word |
| rd_word | output | 32 | Read word captured at the accepted transfer |
| rd_vld | output | 1 | One-clock pulse marking `rd_word` and `chk_n` valid |
| chk_n | output | 1 | Parity status, low = error, valid only while `rd_vld` |

## Verification
The hardest case to reach is a bad lane that the bus-width rules must hide. One example is a 16-bit transfer with all four enables active and a parity error only in the upper half. Another is an 8-bit transfer where the error sits in the second enabled lane. The stimulus builds such transfers on purpose by corrupting a chosen lane's parity bit under set enable and width patterns. It also drives back-to-back reads, reads completed by the burst strobe, and a write that carries a ready strobe. The later random phase mixes all of these.

// File: rtl/lpc_pkg.sv
package lpc_pkg;
  localparam int unsigned LANES  = 4;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned DATA_W = LANES * LANE_W;
  localparam int unsigned HALF   = LANES / 2;

  typedef logic [LANES-1:0]  lane_vec_t;
  typedef logic [DATA_W-1:0] word_t;
endpackage

// File: rtl/lpc_parity_gen.sv
module lpc_parity_gen #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned DATA_W = LANES * LANE_W
) (
  input  logic [DATA_W-1:0] data,
  output logic [LANES-1:0]  par
);
  // one XOR tree per lane: result makes byte+bit even
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign par[g] = ^data[g*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/lpc_lane_select.sv
module lpc_lane_select #(
  parameter int unsigned LANES = 4,
  localparam int unsigned HALF = LANES / 2
) (
  input  logic [LANES-1:0] be_n,
  input  logic             bus16_n,
  input  logic             bus8_n,
  output logic [LANES-1:0] mask
);
  localparam logic [LANES-1:0] LO_MASK = LANES'((1 << HALF) - 1);

  logic [LANES-1:0] en;
  logic             found;

  assign en = ~be_n;

  always_comb begin
    mask  = en;
    found = 1'b0;
    if (!bus8_n) begin
      // byte-wide port: only the first enabled lane carries data
      mask = '0;
      for (int i = 0; i < LANES; i++) begin
        if (en[i] && !found) begin
          mask[i] = 1'b1;
          found   = 1'b1;
        end
      end
    end else if (!bus16_n) begin
      // half-wide port: lower half first, else upper half
      if (|(en & LO_MASK)) mask = en & LO_MASK;
      else                 mask = en & ~LO_MASK;
    end
  end
endmodule

// File: rtl/lpc_read_sample.sv
module lpc_read_sample #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [DATA_W-1:0] data_in,
  input  logic [LANES-1:0]  lane_err,
  input  logic [LANES-1:0]  lane_mask,
  output logic [DATA_W-1:0] data_q,
  output logic              vld_q,
  output logic              bad_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      vld_q  <= 1'b0;
      bad_q  <= 1'b0;
    end else begin
      vld_q <= accept;
      bad_q <= accept & (|(lane_err & lane_mask));
      if (accept) data_q <= data_in;
    end
  end
endmodule

// File: rtl/lane_parity_unit.sv
module lane_parity_unit
  import lpc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              is_write,
  input  logic [LANES-1:0]  be_n,
  input  logic              bus16_n,
  input  logic              bus8_n,
  input  logic              rdy_n,
  input  logic              brdy_n,
  input  logic [DATA_W-1:0] wr_data,
  output logic [LANES-1:0]  wr_par,
  input  logic [DATA_W-1:0] rd_data,
  input  logic [LANES-1:0]  rd_par,
  output logic [DATA_W-1:0] rd_word,
  output logic              rd_vld,
  output logic              chk_n
);
  lane_vec_t rd_calc, lane_err, lane_mask;
  logic      accept, bad_q;

  // R1: write-side parity, aligned with wr_data
  lpc_parity_gen #(.LANES(LANES), .LANE_W(LANE_W)) u_wr_gen (
    .data(wr_data), .par(wr_par)
  );

  // recomputed read parity; mismatch with returned bit = odd lane
  lpc_parity_gen #(.LANES(LANES), .LANE_W(LANE_W)) u_rd_gen (
    .data(rd_data), .par(rd_calc)
  );
  assign lane_err = rd_calc ^ rd_par;

  // R4 R5 R6: lanes taking part in the check
  lpc_lane_select #(.LANES(LANES)) u_sel (
    .be_n(be_n), .bus16_n(bus16_n), .bus8_n(bus8_n), .mask(lane_mask)
  );

  // R2: read completion by either ready strobe
  assign accept = !is_write && (!rdy_n || !brdy_n);

  lpc_read_sample #(.LANES(LANES), .LANE_W(LANE_W)) u_smp (
    .clk(clk), .rst(rst), .accept(accept), .data_in(rd_data),
    .lane_err(lane_err), .lane_mask(lane_mask),
    .data_q(rd_word), .vld_q(rd_vld), .bad_q(bad_q)
  );

  // R3 R7: status low only in the clock after a flagged read
  assign chk_n = ~(rd_vld & bad_q);
endmodule

// File: rtl/lpc_checker.sv
module lpc_checker
  import lpc_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              is_write,
  input logic              rdy_n,
  input logic              brdy_n,
  input logic [DATA_W-1:0] wr_data,
  input logic [LANES-1:0]  wr_par,
  input logic [DATA_W-1:0] rd_data,
  input logic [DATA_W-1:0] rd_word,
  input logic              rd_vld,
  input logic              chk_n
);
  logic rd_take;
  assign rd_take = !is_write && !(rdy_n && brdy_n);

  a_r1_even_total: assert property (@(posedge clk) disable iff (rst)
    (^{wr_data, wr_par}) == 1'b0);

  a_r7_idle_high: assert property (@(posedge clk) disable iff (rst)
    !rd_take |=> chk_n);

  a_r8_write_quiet: assert property (@(posedge clk) disable iff (rst)
    (is_write && !(rdy_n && brdy_n)) |=> (!rd_vld && chk_n));

  a_r9_word_follows: assert property (@(posedge clk) disable iff (rst)
    rd_take |=> (rd_vld && rd_word == $past(rd_data)));

  a_r3_low_needs_vld: assert property (@(posedge clk) disable iff (rst)
    !chk_n |-> rd_vld);
endmodule

bind lane_parity_unit lpc_checker u_chk (.*);

// File: tb/tb_lane_parity_unit.sv
`timescale 1ns/1ps
module tb_lane_parity_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        is_write = 1'b0;
  logic [3:0]  be_n = 4'hF;
  logic        bus16_n = 1'b1, bus8_n = 1'b1, rdy_n = 1'b1, brdy_n = 1'b1;
  logic [31:0] wr_data = '0, rd_data = '0, rd_word;
  logic [3:0]  wr_par, rd_par = '0;
  logic        rd_vld, chk_n;

  int checks = 0, fails = 0;
  logic run = 1'b0;

  typedef struct packed { logic st; logic [31:0] d; } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  lane_parity_unit dut (.*);

  function automatic logic [3:0] good_par(input logic [31:0] d);
    logic [3:0] p;
    for (int i = 0; i < 4; i++) p[i] = ^d[8*i +: 8];
    return p;
  endfunction

  function automatic logic exp_status(input logic [31:0] d, input logic [3:0] p,
      input logic [3:0] ben, input logic b16, input logic b8);
    logic [3:0] en, use_l, odd;
    logic hit;
    en = ~ben; use_l = en; hit = 1'b0;
    if (!b8) begin            // R6
      use_l = 4'b0;
      for (int i = 0; i < 4; i++) if (en[i] && !hit) begin use_l[i] = 1'b1; hit = 1'b1; end
    end else if (!b16) begin  // R5
      use_l = (en[0] | en[1]) ? (en & 4'b0011) : (en & 4'b1100);
    end
    for (int i = 0; i < 4; i++) odd[i] = ^{d[8*i +: 8], p[i]};
    return !(|(use_l & odd));
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // driver: one read beat, strobes left asserted for the caller to release
  task automatic put_read(input logic [31:0] d, input logic [3:0] flip,
      input logic [3:0] ben, input logic b16, input logic b8, input logic burst);
    exp_t e;
    is_write = 1'b0; rd_data = d; rd_par = good_par(d) ^ flip;
    be_n = ben; bus16_n = b16; bus8_n = b8;
    rdy_n = burst; brdy_n = !burst;
    e.st = exp_status(d, rd_par, ben, b16, b8); e.d = d;
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic idle;
    rdy_n = 1'b1; brdy_n = 1'b1; is_write = 1'b0;
    @(negedge clk);
  endtask

  task automatic put_write(input logic [31:0] d, input logic strobe);
    is_write = 1'b1; wr_data = d; rdy_n = !strobe; brdy_n = 1'b1;
    rd_data = ~d; rd_par = 4'h0;   // garbage that must not be judged (R8)
    #1 check("R1 wr_par", {28'h0, wr_par}, {28'h0, good_par(d)});
    @(negedge clk);
    rdy_n = 1'b1; is_write = 1'b0;
    #0.5 check("R8 no pulse after write strobe", {30'h0, rd_vld, chk_n}, 32'h1);
    @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (run && !rst) begin
      if (rd_vld) begin
        if (q.size() == 0) begin
          check("R9 unexpected rd_vld", 32'h1, 32'h0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check("R3 chk_n", {31'h0, chk_n}, {31'h0, e.st});
          check("R9 rd_word", rd_word, e.d);
        end
      end else begin
        check("R7 chk_n idle", {31'h0, chk_n}, 32'h1);
      end
    end
  end

  initial begin
    #(5.0 * 150000);
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset chk_n", {31'h0, chk_n}, 32'h1);
    check("R10 reset rd_vld", {31'h0, rd_vld}, 32'h0);
    check("R10 reset rd_word", rd_word, 32'h0);
    rst = 1'b0; run = 1'b1;
    idle();
    // R4 full width
    put_read(32'h1234_5678, 4'b0000, 4'b0000, 1, 1, 0); idle();
    put_read(32'hA5A5_0F0F, 4'b0100, 4'b0000, 1, 1, 0); idle();
    put_read(32'hA5A5_0F0F, 4'b0100, 4'b0100, 1, 1, 0); idle();
    // R2 burst strobe, back-to-back
    put_read(32'hDEAD_BEEF, 4'b0001, 4'b0000, 1, 1, 1);
    put_read(32'hCAFE_F00D, 4'b0000, 4'b0000, 1, 1, 1);
    put_read(32'h0000_00FF, 4'b1000, 4'b0000, 1, 1, 1); idle();
    // R5 half width
    put_read(32'h1111_2222, 4'b1000, 4'b0000, 0, 1, 0); idle();
    put_read(32'h1111_2222, 4'b0010, 4'b0000, 0, 1, 0); idle();
    put_read(32'h3333_4444, 4'b1000, 4'b0011, 0, 1, 0); idle();
    // R6 byte width, and byte width overriding half width
    put_read(32'h5555_6666, 4'b0010, 4'b0000, 1, 0, 0); idle();
    put_read(32'h5555_6666, 4'b0010, 4'b1001, 1, 0, 0); idle();
    put_read(32'h5555_6666, 4'b0100, 4'b1001, 0, 0, 0); idle();
    // both strobes at once: one transfer (R2)
    is_write = 1'b0; rd_data = 32'h7777_8888; rd_par = good_par(32'h7777_8888) ^ 4'b0001;
    be_n = 4'b0000; bus16_n = 1; bus8_n = 1; rdy_n = 0; brdy_n = 0;
    q.push_back('{st: 1'b0, d: 32'h7777_8888});
    @(negedge clk); idle();
    // R8 writes with and without strobe, R1
    put_write(32'h0102_0408, 1);
    put_write(32'hFFFF_0001, 0);
    // random mix
    for (int n = 0; n < 60; n++) begin
      logic [31:0] rw;
      rw = $urandom;
      put_read(rw, 4'($urandom), 4'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      if (n % 3 == 0) idle();
    end
    idle(); idle();
    // R10 reset after activity clears captured word
    rst = 1'b1; @(negedge clk); @(negedge clk);
    check("R10 reset rd_word after use", rd_word, 32'h0);
    check("R10 reset chk_n after use", {31'h0, chk_n}, 32'h1);
    rst = 1'b0;
    idle(); idle();
    check("R9 queue drained", q.size(), 32'h0);
    finish_run();
  end
endmodule